// File: doc/BRIEF.md
# GPIO Controller with Edge-Detect Interrupts

This block controls 28 general-purpose I/O lines. Software reaches it through a simple register bus that completes in one cycle. For each pin, software can choose the direction and drive an output latch. It can read back the synchronised pin level and give the pad over to an alternate-function source. Pin n maps to bit n of every register. The output latch has no direct write path. It changes only through two registers, one that sets bits and one that clears bits, so no read-modify-write is needed.

Each input passes through a two-flop synchroniser. An edge detector compares the synchronised value with its value one cycle earlier. Separate rising and falling enables decide which edges are recorded in a sticky status register, and software clears a status bit by writing one to it. Pins 0 to 10 each drive their own interrupt line. Pins 11 to 27 share a single interrupt line, which is the OR of their status bits.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, direction, output latch, rising and falling enables, edge status and alternate-function select all read zero. Every pin output, output enable and interrupt output is low.
- R2: The bus is byte-addressed, and bus_addr_i[4:2] selects the register. The offsets are: 0x04 direction (1 = output), 0x10 rising enable, 0x14 falling enable and 0x1C alternate select, all read/write. The other registers are at 0x00 (level, read), 0x08 (set), 0x0C (clear) and 0x18 (status). Bits above bit 27 read as zero. With the alternate bit at 0, pin_oe_o equals the direction bit.
- R3: A write to 0x08 sets each latch bit written as 1 and leaves bits written as 0 unchanged. The latch drives pin_out_o.
- R4: A write to 0x0C clears each latch bit written as 1 and leaves bits written as 0 unchanged.
- R5: Offsets 0x08 and 0x0C always read as zero.
- R6: Offset 0x00 returns pin_in_i as sampled two clock edges earlier, whatever the direction.
- R7: A 0-to-1 transition on a pin whose rising enable is set makes its status bit 1 three edges after the input change. The same transition with the enable clear leaves the status bit at 0.
- R8: A 1-to-0 transition on a pin whose falling enable is set sets its status bit. With both enables set, either transition sets it.
- R9: A status bit stays 1 until a bus write to 0x18 with that bit at 1. Writing 0 leaves it set.
- R10: If a qualifying edge and a write-one-to-clear reach the same status bit in the same cycle, the bit stays 1.
- R11: irq_pin_o[n] is high exactly while status bit n is set, for n = 0 to 10.
- R12: irq_shared_o is high exactly while any status bit from 11 to 27 is set.
- R13: When alternate-select bit n is 1, pin_out_o[n] and pin_oe_o[n] take alt_out_i[n] and alt_oe_i[n] in place of the latch and direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, available in the same cycle |
| pin_in_i | input | 28 | Pad input levels |
| pin_out_o | output | 28 | Pad output values |
| pin_oe_o | output | 28 | Pad output enables |
| alt_out_i | input | 28 | Alternate-function output values |
| alt_oe_i | input | 28 | Alternate-function output enables |
| irq_pin_o | output | 11 | Dedicated interrupts for pins 0 to 10 |
| irq_shared_o | output | 1 | Combined interrupt for pins 11 to 27 |

## Verification
Four properties are checked on every cycle. A status bit never drops unless a write-one-to-clear covered it. A status bit never rises without an enabled edge the cycle before. A colliding edge always wins over a clear. The set and clear offsets always read as zero. Two further per-cycle properties check that each set write shows up on the latch and that the shared interrupt follows the upper status bits. The bench scenarios are needed for the rest: the exact three-edge latency from pad to status, the two-edge latency to the level register, mixed and masked edge enables, the alternate-function override, and a clear timed to land on the same edge as a new event.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned REG_IDX_W = 3;

  // word index = byte offset >> 2
  typedef enum logic [REG_IDX_W-1:0] {
    IDX_LEVEL = 3'd0,
    IDX_DIR   = 3'd1,
    IDX_SET   = 3'd2,
    IDX_CLR   = 3'd3,
    IDX_RISE  = 3'd4,
    IDX_FALL  = 3'd5,
    IDX_STAT  = 3'd6,
    IDX_ALT   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_PINS = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_idx_e          idx_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] out_o,
  output logic [N_PINS-1:0] rise_en_o,
  output logic [N_PINS-1:0] fall_en_o,
  output logic [N_PINS-1:0] alt_o
);
  logic [N_PINS-1:0] dir_q, out_q, rise_q, fall_q, alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      alt_q  <= '0;
    end else if (wr_en_i) begin
      unique case (idx_i)
        IDX_DIR:  dir_q  <= wdata_i;
        IDX_SET:  out_q  <= out_q | wdata_i;
        IDX_CLR:  out_q  <= out_q & ~wdata_i;
        IDX_RISE: rise_q <= wdata_i;
        IDX_FALL: fall_q <= wdata_i;
        IDX_ALT:  alt_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign dir_o     = dir_q;
  assign out_o     = out_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign alt_o     = alt_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N_PINS   = 28,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] rise_en_i,
  input  logic [N_PINS-1:0] fall_en_i,
  output logic [N_PINS-1:0] level_o,
  output logic [N_PINS-1:0] event_o
);
  logic [N_PINS-1:0] stage_q [SYNC_LEN];
  logic [N_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_LEN; i++) stage_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int i = 1; i < SYNC_LEN; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[SYNC_LEN-1];
    end
  end

  assign level_o = stage_q[SYNC_LEN-1];

  for (genvar p = 0; p < N_PINS; p++) begin : g_edge
    logic rise_s, fall_s;
    assign rise_s     = level_o[p] & ~prev_q[p];
    assign fall_s     = ~level_o[p] & prev_q[p];
    assign event_o[p] = (rise_s & rise_en_i[p]) | (fall_s & fall_en_i[p]);
  end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int unsigned N_PINS   = 28,
  parameter int unsigned N_DIRECT = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PINS-1:0]   event_i,
  input  logic                clr_en_i,
  input  logic [N_PINS-1:0]   clr_mask_i,
  output logic [N_PINS-1:0]   status_o,
  output logic [N_DIRECT-1:0] irq_direct_o,
  output logic                irq_shared_o
);
  localparam int unsigned N_SHARED = N_PINS - N_DIRECT;

  logic [N_PINS-1:0] stat_q, clr_s;

  assign clr_s = clr_en_i ? clr_mask_i : '0;

  // a new event wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_s) | event_i;
  end

  for (genvar d = 0; d < N_DIRECT; d++) begin : g_direct
    assign irq_direct_o[d] = stat_q[d];
  end

  if (N_SHARED > 0) begin : g_shared
    assign irq_shared_o = |stat_q[N_PINS-1:N_DIRECT];
  end else begin : g_no_shared
    assign irq_shared_o = 1'b0;
  end

  assign status_o = stat_q;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_PINS       = 28,
  parameter int unsigned N_DIRECT_IRQ = 11,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_sel_i,
  input  logic                    bus_we_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic [DATA_W-1:0]       bus_rdata_o,
  input  logic [N_PINS-1:0]       pin_in_i,
  output logic [N_PINS-1:0]       pin_out_o,
  output logic [N_PINS-1:0]       pin_oe_o,
  input  logic [N_PINS-1:0]       alt_out_i,
  input  logic [N_PINS-1:0]       alt_oe_i,
  output logic [N_DIRECT_IRQ-1:0] irq_pin_o,
  output logic                    irq_shared_o
);
  localparam int unsigned PAD_W = DATA_W - N_PINS;

  reg_idx_e          idx_s;
  logic              wr_s;
  logic [N_PINS-1:0] wdata_s;
  logic [N_PINS-1:0] dir_q, out_q, rise_en_q, fall_en_q, alt_q;
  logic [N_PINS-1:0] level_s, event_s, status_q;
  logic [N_PINS-1:0] rd_s;
  logic              unused_bus;

  assign idx_s      = reg_idx_e'(bus_addr_i[REG_IDX_W+1:2]);
  assign wr_s       = bus_sel_i & bus_we_i;
  assign wdata_s    = bus_wdata_i[N_PINS-1:0];
  assign unused_bus = ^{bus_wdata_i[DATA_W-1:N_PINS], bus_addr_i[1:0]};

  gpio_ctrl_regs #(.N_PINS(N_PINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_s),
    .idx_i     (idx_s),
    .wdata_i   (wdata_s),
    .dir_o     (dir_q),
    .out_o     (out_q),
    .rise_en_o (rise_en_q),
    .fall_en_o (fall_en_q),
    .alt_o     (alt_q)
  );

  gpio_in_sync #(.N_PINS(N_PINS), .SYNC_LEN(2)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_in_i),
    .rise_en_i (rise_en_q),
    .fall_en_i (fall_en_q),
    .level_o   (level_s),
    .event_o   (event_s)
  );

  gpio_edge_status #(.N_PINS(N_PINS), .N_DIRECT(N_DIRECT_IRQ)) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .event_i      (event_s),
    .clr_en_i     (wr_s && idx_s == IDX_STAT),
    .clr_mask_i   (wdata_s),
    .status_o     (status_q),
    .irq_direct_o (irq_pin_o),
    .irq_shared_o (irq_shared_o)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_pad
    assign pin_out_o[p] = alt_q[p] ? alt_out_i[p] : out_q[p];
    assign pin_oe_o[p]  = alt_q[p] ? alt_oe_i[p]  : dir_q[p];
  end

  always_comb begin
    unique case (idx_s)
      IDX_LEVEL: rd_s = level_s;
      IDX_DIR:   rd_s = dir_q;
      IDX_RISE:  rd_s = rise_en_q;
      IDX_FALL:  rd_s = fall_en_q;
      IDX_STAT:  rd_s = status_q;
      IDX_ALT:   rd_s = alt_q;
      default:   rd_s = '0;
    endcase
  end

  assign bus_rdata_o = {{PAD_W{1'b0}}, rd_s};
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int unsigned N_PINS   = 28,
  parameter int unsigned N_DIRECT = 11,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_shared_o,
  input logic [N_PINS-1:0] level_i,
  input logic [N_PINS-1:0] rise_en_i,
  input logic [N_PINS-1:0] fall_en_i,
  input logic [N_PINS-1:0] out_i,
  input logic [N_PINS-1:0] status_i
);
  logic [N_PINS-1:0] lvl_prev_q, qual_s, clr_s, wmask_s;
  logic              wr_set_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_prev_q <= '0;
    else         lvl_prev_q <= level_i;
  end

  assign wmask_s  = bus_wdata_i[N_PINS-1:0];
  assign qual_s   = (level_i & ~lvl_prev_q & rise_en_i) | (~level_i & lvl_prev_q & fall_en_i);
  assign clr_s    = (bus_sel_i && bus_we_i && bus_addr_i[4:2] == 3'd6) ? wmask_s : '0;
  assign wr_set_s = bus_sel_i && bus_we_i && bus_addr_i[4:2] == 3'd2;

  // R9: status bits only fall under a write-one-to-clear
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_i) & ~$past(clr_s) & ~status_i) == '0));

  // R7: status bits only rise after an enabled edge
  p_set_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~$past(status_i) & status_i & ~$past(qual_s)) == '0));

  // R10: a colliding edge keeps the bit set
  p_collision_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(qual_s) & ~status_i) == '0));

  // R5: set/clear offsets read zero
  p_setclr_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i[4:2] == 3'd2 || bus_addr_i[4:2] == 3'd3) |-> bus_rdata_o == '0);

  // R3: set write lands in the latch
  p_set_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_s |=> (($past(wmask_s) & ~out_i) == '0));

  // R12: shared line follows upper status bits
  p_shared_irq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_shared_o == (status_i[N_PINS-1:N_DIRECT] != '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
  .N_PINS(N_PINS), .N_DIRECT(N_DIRECT_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_sel_i    (bus_sel_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .irq_shared_o (irq_shared_o),
  .level_i      (level_s),
  .rise_en_i    (rise_en_q),
  .fall_en_i    (fall_en_q),
  .out_i        (out_q),
  .status_i     (status_q)
);

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
  localparam int NP = 28;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [4:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [NP-1:0] pin_in_i = '0, pin_out_o, pin_oe_o;
  logic [NP-1:0] alt_out_i = '0, alt_oe_i = '0;
  logic [10:0] irq_pin_o;
  logic        irq_shared_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_edge_ctrl u_dut (
    .clk_i, .rst_ni, .bus_sel_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .pin_in_i, .pin_out_o, .pin_oe_o, .alt_out_i, .alt_oe_i,
    .irq_pin_o, .irq_shared_o
  );

  localparam logic [2:0] LVL = 0, DIR = 1, SETR = 2, CLRR = 3, RISE = 4, FALL = 5, STAT = 6, ALT = 7;

  typedef struct packed {
    logic        we;
    logic [2:0]  idx;
    logic [31:0] data;   // write data or expected read
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, DIR,  32'h0,          8'd1},  // R1
    '{1'b0, STAT, 32'h0,          8'd1},  // R1
    '{1'b0, ALT,  32'h0,          8'd1},  // R1
    '{1'b1, DIR,  32'h0F0F_00FF,  8'd2},
    '{1'b0, DIR,  32'h0F0F_00FF,  8'd2},  // R2
    '{1'b1, RISE, 32'hFFFF_FFFF,  8'd2},
    '{1'b0, RISE, 32'h0FFF_FFFF,  8'd2},  // R2 upper bits zero
    '{1'b1, FALL, 32'h0000_0AAA,  8'd2},
    '{1'b0, FALL, 32'h0000_0AAA,  8'd2},
    '{1'b1, SETR, 32'h0000_0F0F,  8'd5},
    '{1'b0, SETR, 32'h0,          8'd5},  // R5
    '{1'b0, CLRR, 32'h0,          8'd5},  // R5
    '{1'b1, RISE, 32'h0,          8'd2},
    '{1'b1, FALL, 32'h0,          8'd2},
    '{1'b1, DIR,  32'h0,          8'd2},
    '{1'b0, STAT, 32'h0,          8'd7}   // R7 no edges enabled
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = {idx, 2'b00}; bus_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = {idx, 2'b00};
    #1 d = bus_rdata_o;
    bus_sel_i = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    edges(2);
    rst_ni = 1'b1;
    edges(1);
    // R1 reset outputs
    check("R1 pin_out", 32'(pin_out_o), 32'h0);
    check("R1 pin_oe", 32'(pin_oe_o), 32'h0);
    check("R1 irq", {20'h0, irq_shared_o, irq_pin_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].idx, VECS[i].data);
      else begin
        rd(VECS[i].idx, r);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), r, VECS[i].data);
      end
    end

    // R3 / R4 latch via set and clear
    wr(CLRR, 32'h0FFF_FFFF);
    wr(DIR, 32'h0FFF_FFFF);
    check("R2 oe follows dir", 32'(pin_oe_o), 32'h0FFF_FFFF);
    wr(SETR, 32'h5);
    check("R3 set", 32'(pin_out_o), 32'h5);
    wr(SETR, 32'h0);
    check("R3 zero no effect", 32'(pin_out_o), 32'h5);
    wr(CLRR, 32'h1);
    check("R4 clear", 32'(pin_out_o), 32'h4);
    wr(CLRR, 32'h0);
    check("R4 zero no effect", 32'(pin_out_o), 32'h4);

    // R13 alternate function
    alt_out_i = '1; alt_oe_i = '0;
    wr(ALT, 32'h1);
    check("R13 alt out", 32'(pin_out_o), 32'h5);
    check("R13 alt oe", 32'(pin_oe_o), 32'h0FFF_FFFE);
    wr(ALT, 32'h0);
    check("R13 alt off", 32'(pin_out_o), 32'h4);

    // R6 level latency, pins set as outputs
    pin_in_i = 28'h0000123;
    edges(1);
    rd(LVL, r); check("R6 after one edge", r, 32'h0);
    edges(1);
    rd(LVL, r); check("R6 after two edges", r, 32'h123);
    wr(DIR, 32'h0);
    rd(LVL, r); check("R6 as input", r, 32'h123);
    pin_in_i = '0;
    edges(3);

    // R7 rising with and without enable
    wr(RISE, 32'h8);
    pin_in_i = 28'h18;
    edges(2);
    rd(STAT, r); check("R7 not yet at two edges", r, 32'h0);
    edges(1);
    rd(STAT, r); check("R7 rise sets only enabled pin", r, 32'h8);
    check("R11 dedicated irq", 32'(irq_pin_o), 32'h8);
    check("R12 shared idle", 32'(irq_shared_o), 32'h0);

    // R9 sticky and clear
    wr(STAT, 32'h0);
    rd(STAT, r); check("R9 write zero keeps", r, 32'h8);
    wr(STAT, 32'h8);
    rd(STAT, r); check("R9 write one clears", r, 32'h0);
    check("R11 irq drops", 32'(irq_pin_o), 32'h0);

    // R8 falling, then both
    wr(RISE, 32'h0);
    wr(FALL, 32'h8);
    pin_in_i = 28'h10;
    edges(3);
    rd(STAT, r); check("R8 fall", r, 32'h8);
    wr(STAT, 32'h8);
    wr(FALL, 32'h0);
    wr(RISE, 32'h20); wr(FALL, 32'h20);
    pin_in_i = 28'h30;
    edges(3);
    rd(STAT, r); check("R8 both rise", r, 32'h20);
    check("R11 pin5 irq", 32'(irq_pin_o), 32'h20);
    wr(STAT, 32'h20);
    pin_in_i = 28'h10;
    edges(3);
    rd(STAT, r); check("R8 both fall", r, 32'h20);
    wr(STAT, 32'h20);
    wr(RISE, 32'h0); wr(FALL, 32'h0);

    // R12 shared interrupt
    wr(RISE, 32'h0010_0000);
    pin_in_i = 28'h0100010;
    edges(3);
    check("R12 shared high", 32'(irq_shared_o), 32'h1);
    check("R12 no dedicated", 32'(irq_pin_o), 32'h0);
    wr(STAT, 32'h0010_0000);
    check("R12 shared low", 32'(irq_shared_o), 32'h0);

    // R10 clear colliding with a new event
    wr(FALL, 32'h0010_0000);
    pin_in_i = 28'h0000010;
    edges(3);
    rd(STAT, r); check("R10 setup", r, 32'h0010_0000);
    pin_in_i = 28'h0100010;
    edges(2);
    wr(STAT, 32'h0010_0000);
    rd(STAT, r); check("R10 edge wins over clear", r, 32'h0010_0000);
    wr(STAT, 32'h0010_0000);
    rd(STAT, r); check("R10 later clear works", r, 32'h0);

    finish_run();
  end
endmodule